// File: doc/BRIEF.md
# Dual-Channel Double-Buffered Converter Register Front End

This block is the clocked digital front end of a two-channel, 12-bit converter. A host drives a 12-bit parallel data bus together with an active-low chip select and a channel select. Each channel has a staging register that captures the bus while it is written. Each channel also has a code register whose value goes to the analog side. That code register copies the staging register while the channel's active-low load strobe is held low. Both code registers are presented as outputs.

Because the strobes act on level, the host has three ways to update the outputs. It can stage both channels and then pulse both strobes together, so that both outputs change in the same cycle. It can pulse one strobe to update one channel. It can hold both strobes low, so that the bus runs straight through to the outputs with a fixed two-clock latency. An active-low reset, asserted asynchronously and released through a two-stage synchroniser, loads every register with zero scale or midscale. A separate level input picks between the two while reset is active.

Top module: `dac_fe`

## Requirements
- R1: Within one clock edge of `rst_n` going low, both staging registers and both code outputs equal 12'h000 if `mid_sel` is 0, or 12'h800 if `mid_sel` is 1.
- R2: After `rst_n` rises, with `cs_n` and both `ld_n` bits held high, every register keeps the reset value.
- R3: A clock edge with `cs_n` low writes `data` into one staging register: channel A when `ch_sel` is 0, channel B when `ch_sel` is 1. The other channel's staging register is unchanged.
- R4: While `cs_n` is high, the staging registers ignore `data` and hold.
- R5: While a channel's strobe (`ld_n[0]` for A, `ld_n[1]` for B) is high, its code output holds, even across writes to its staging register.
- R6: A clock edge with one strobe low loads that channel's code register with the value its staging register had before the edge. The other channel's output is unchanged.
- R7: With both strobes low in the same cycle, both code outputs update on the same clock edge.
- R8: With `cs_n` low and both strobes low, a bus value driven before edge n appears on the selected channel's output after edge n+1.
- R9: Reset overrides chip select and the strobes. While it is active, a write or a load has no effect on any register.
- R10: `dac_code[11:0]` carries channel A and `dac_code[23:12]` carries channel B. In each field the most significant bit is the top bit, in natural binary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assertion |
| mid_sel | input | 1 | Reset level: 0 selects zero scale, 1 selects midscale |
| cs_n | input | 1 | Active-low write enable for the staging registers |
| ch_sel | input | 1 | Write target: 0 selects channel A, 1 selects channel B |
| ld_n | input | 2 | Active-low load strobes, bit 0 for channel A, bit 1 for channel B |
| data | input | 12 | Parallel data bus |
| dac_code | output | 24 | Code registers of both channels, packed |

## Verification
The assertions assume that every control input is already synchronous to `clk`. They also assume that `mid_sel` stays steady from the moment reset goes low until the synchronised release, because the register loads use the current level on every reset cycle. The bench changes inputs only on falling clock edges. It sets `mid_sel` in the same step that pulls `rst_n` low and leaves it alone until several cycles after `rst_n` returns high. Staging contents are observed only through the normal load path.

// File: rtl/dac_fe_pkg.sv
package dac_fe_pkg;
  localparam int unsigned CODE_W = 12;

  function automatic logic [CODE_W-1:0] reset_code(input logic mid);
    reset_code = mid ? {1'b1, {(CODE_W-1){1'b0}}} : '0;
  endfunction
endpackage

// File: rtl/dac_fe_rst_sync.sv
module dac_fe_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/dac_fe_chan.sv
module dac_fe_chan #(
  parameter int unsigned DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_sync_n,
  input  logic [DATA_W-1:0] rst_val,
  input  logic              wr_en,
  input  logic              ld_en,
  input  logic [DATA_W-1:0] data,
  output logic [DATA_W-1:0] code
);
  logic [DATA_W-1:0] stage_q, stage_d;
  logic [DATA_W-1:0] code_q, code_d;

  always_comb begin
    stage_d = stage_q;
    code_d  = code_q;
    if (!rst_sync_n) begin
      stage_d = rst_val;
      code_d  = rst_val;
    end else begin
      if (wr_en) stage_d = data;
      if (ld_en) code_d  = stage_q;
    end
  end

  always_ff @(posedge clk) begin
    stage_q <= stage_d;
    code_q  <= code_d;
  end

  assign code = code_q;

  // R3
  p_write_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_en |=> stage_q == $past(data));
  // R4
  p_stage_hold_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !wr_en |=> $stable(stage_q));
  // R5
  p_code_hold_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !ld_en |=> $stable(code_q));
  // R6
  p_code_load_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ld_en |=> code_q == $past(stage_q));
endmodule

// File: rtl/dac_fe.sv
module dac_fe
  import dac_fe_pkg::*;
#(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned DATA_W = CODE_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     mid_sel,
  input  logic                     cs_n,
  input  logic [SEL_W-1:0]         ch_sel,
  input  logic [NUM_CH-1:0]        ld_n,
  input  logic [DATA_W-1:0]        data,
  output logic [NUM_CH*DATA_W-1:0] dac_code
);
  localparam int unsigned SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic              rst_sync_n;
  logic [DATA_W-1:0] rst_val;
  logic [NUM_CH-1:0] wr_en;

  dac_fe_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign rst_val = mid_sel ? {1'b1, {(DATA_W-1){1'b0}}} : '0;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign wr_en[i] = !cs_n && (ch_sel == SEL_W'(i));

    dac_fe_chan #(.DATA_W(DATA_W)) u_chan (
      .clk        (clk),
      .rst_sync_n (rst_sync_n),
      .rst_val    (rst_val),
      .wr_en      (wr_en[i]),
      .ld_en      (!ld_n[i]),
      .data       (data),
      .code       (dac_code[i*DATA_W +: DATA_W])
    );
  end

  // R3: at most one staging register is written per cycle
  p_one_write_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0(wr_en));
  // R9: synchronised reset is low whenever raw reset is low
  p_rst_prio_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_sync_n) |-> $past(rst_n));
endmodule

// File: tb/dac_fe_tb.sv
module dac_fe_tb;
  localparam int W = 12;

  logic          clk = 1'b0;
  logic          rst_n, mid_sel, cs_n, ch_sel;
  logic [1:0]    ld_n;
  logic [W-1:0]  data;
  logic [2*W-1:0] dac_code;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  dac_fe u_dut (
    .clk(clk), .rst_n(rst_n), .mid_sel(mid_sel), .cs_n(cs_n),
    .ch_sel(ch_sel), .ld_n(ld_n), .data(data), .dac_code(dac_code)
  );

  function automatic logic [W-1:0] out_a(); return dac_code[W-1:0]; endfunction
  function automatic logic [W-1:0] out_b(); return dac_code[2*W-1:W]; endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_ch(input logic ch, input logic [W-1:0] v);
    @(negedge clk); cs_n = 1'b0; ch_sel = ch; data = v;
    @(negedge clk); cs_n = 1'b1; data = ~v;
  endtask

  task automatic load(input logic [1:0] mask);
    @(negedge clk); ld_n = ~mask;
    @(negedge clk); ld_n = 2'b11;
  endtask

  task automatic t_reset(input logic lvl);
    logic [W-1:0] rv = lvl ? 12'h800 : 12'h000;
    @(negedge clk); rst_n = 1'b0; mid_sel = lvl;
    @(negedge clk);
    check("R1 a", out_a(), rv);
    check("R1 b", out_b(), rv);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R2 a", out_a(), rv);
    check("R2 b", out_b(), rv);
    load(2'b11);
    check("R1 stage a", out_a(), rv);
    check("R1 stage b", out_b(), rv);
  endtask

  task automatic t_write_no_change();
    logic [W-1:0] a0 = out_a(), b0 = out_b();
    write_ch(1'b0, 12'h5A3);
    write_ch(1'b1, 12'hC3C);
    @(negedge clk);
    check("R5 a hold", out_a(), a0);
    check("R5 b hold", out_b(), b0);
    data = 12'h111;
    repeat (3) @(negedge clk);
    load(2'b11);
    check("R4 a bus ignored", out_a(), 12'h5A3);
    check("R4 b bus ignored", out_b(), 12'hC3C);
  endtask

  task automatic t_joint_load();
    write_ch(1'b0, 12'h0F1);
    write_ch(1'b1, 12'hE2D);
    @(negedge clk); ld_n = 2'b00;
    @(posedge clk); #1;
    check("R7 a same edge", out_a(), 12'h0F1);
    check("R7 b same edge", out_b(), 12'hE2D);
    @(negedge clk); ld_n = 2'b11;
  endtask

  task automatic t_single_load();
    write_ch(1'b0, 12'h321);
    write_ch(1'b1, 12'h654);
    load(2'b01);
    check("R6 a loaded", out_a(), 12'h321);
    check("R6 b untouched", out_b(), 12'hE2D);
    load(2'b10);
    check("R6 b loaded", out_b(), 12'h654);
    check("R3 a not hit by b write", out_a(), 12'h321);
  endtask

  task automatic t_transparent();
    @(negedge clk); ld_n = 2'b00; cs_n = 1'b0; ch_sel = 1'b0; data = 12'hFFF;
    @(negedge clk);
    check("R8 one edge a", out_a(), 12'h321);
    @(negedge clk);
    check("R8 two edges a", out_a(), 12'hFFF);
    check("R10 msb a", {11'd0, dac_code[11]}, 12'h001);
    ch_sel = 1'b1; data = 12'h801;
    @(negedge clk); @(negedge clk);
    check("R8 b", out_b(), 12'h801);
    check("R10 b field", {11'd0, dac_code[23]}, 12'h001);
    cs_n = 1'b1; ld_n = 2'b11;
  endtask

  task automatic t_priority();
    @(negedge clk); rst_n = 1'b0; mid_sel = 1'b1;
    cs_n = 1'b0; ld_n = 2'b00; ch_sel = 1'b0; data = 12'h7AB;
    repeat (3) @(negedge clk);
    check("R9 a", out_a(), 12'h800);
    check("R9 b", out_b(), 12'h800);
    cs_n = 1'b1; ld_n = 2'b11;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    load(2'b11);
    check("R9 stage a", out_a(), 12'h800);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; mid_sel = 1'b0; cs_n = 1'b1; ch_sel = 1'b0;
    ld_n = 2'b11; data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset(1'b0);
    t_write_no_change();
    t_joint_load();
    t_single_load();
    t_transparent();
    t_reset(1'b1);
    t_priority();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule